// File: doc/BRIEF.md
# Interrupt Entry and Return Stacking Sequencer

This block sits beside a small 8-bit CPU core and handles the memory side of interrupt entry, return-from-interrupt, subroutine call and subroutine return. It keeps the hardware stack pointer and latches interrupt requests. When the CPU signals an instruction boundary and a request is ready, the block writes the CPU state into a 64-byte stack page, one byte per cycle. It then reads the two-byte vector for the winning request and hands the CPU a new program counter and a condition code value with the interrupt mask set. On return, the block reads the saved bytes back in reverse order and presents them for the CPU to reload.

The stack pointer is 16 bits wide. Only its low six bits are stored; the upper ten are constant. Pushes and pulls therefore wrap silently inside the page from $00C0 to $00FF. Requests that arrive while the mask bit (condition code bit 3) is set stay latched. The block offers them once software clears the mask. After reset the block fetches the reset vector by itself.

The controller has six states. IDLE accepts commands. PUSH writes one stacked byte per cycle. PULL reads one saved byte per cycle. VEC_HI and VEC_LO read the two vector bytes. FINISH presents the results for one cycle. Out of reset the controller starts in VEC_HI, then goes VEC_HI to VEC_LO to FINISH. The other transitions are:
- IDLE to PUSH on a call or an accepted interrupt entry.
- IDLE to PULL on a return-from-interrupt or a subroutine return.
- PUSH to VEC_HI after the fifth byte of an interrupt frame.
- PUSH to FINISH after the second byte of a call.
- PULL to FINISH after the last byte.
- FINISH to IDLE.
- IDLE stays in IDLE on a stack-pointer reset command or on an entry request that is not ready.

Top module: `irq_stack_seq`

## Requirements
- R1: Every stack access uses an address whose upper ten bits are 0000000011, so stack addresses lie in $00C0..$00FF.
- R2: Reset and the stack-reset command (`rsp_i` in IDLE) set `sp_o` to $00FF; after the command `sp_o` reads $00FF at the next falling edge.
- R3: A push writes at `sp_o` and then decrements it. A pull increments first and reads at the new value. The low six bits wrap from $00C0 to $00FF, and the reverse, with no flag.
- R4: Interrupt entry writes five bytes in the order PC[7:0], PC[15:8], X, A, CCR, where the stacked CCR has bits 7:5 forced to 111. A call writes PC[7:0] and then PC[15:8].
- R5: Return-from-interrupt reads CCR, A, X, PC high, PC low and raises `pc_load_o`, `ccr_load_o` and `ax_load_o` with those values. Subroutine return reads PC high and then PC low and raises only `pc_load_o`.
- R6: An accepted entry is followed by a vector fetch: high byte, then low byte at the next address. FINISH loads that PC and a CCR equal to the pre-entry CCR with bits 7:5 and bit 3 set.
- R7: A request that arrives while CCR bit 3 is 1 stays latched. Meanwhile `irq_pending_o` is 0 and `enter_i` causes no memory write. After bit 3 is cleared, `irq_pending_o` rises and the request is taken.
- R8: After reset the block reads $3FFE (high) and $3FFF (low), then loads that PC and CCR = $E8. Every CCR the block loads has bits 7:5 = 111.
- R9: Every loaded PC has bits 15:14 cleared.
- R10: Request line k has its vector high byte at $3FFA - 2k. When several requests are pending, the lowest index is taken first.
- R11: Commands are accepted only in IDLE, in the priority order stack reset, return-from-interrupt, subroutine return, call, entry. Strobes during a sequence are ignored.
- R12: `done_o` is high for exactly one cycle at the end of each sequence, including the reset vector fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_req_i | input | N_REQ | Request pulses, one per source; index 0 has highest priority |
| cpu_pc_i | input | 16 | Current program counter |
| cpu_a_i | input | 8 | Current accumulator |
| cpu_x_i | input | 8 | Current index register |
| cpu_ccr_i | input | 8 | Current condition codes; bit 3 is the interrupt mask |
| enter_i | input | 1 | Instruction boundary: take a ready interrupt |
| rti_i | input | 1 | Return-from-interrupt command |
| call_i | input | 1 | Subroutine call: stack the PC |
| rts_i | input | 1 | Subroutine return: unstack the PC |
| rsp_i | input | 1 | Reset stack pointer to $00FF |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid in the same cycle |
| sp_o | output | 16 | Stack pointer |
| irq_pending_o | output | 1 | A latched request is ready and the mask is clear |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | Last cycle of a sequence |
| pc_load_o | output | 1 | `pc_o` is valid for loading |
| pc_o | output | 16 | New program counter |
| ccr_load_o | output | 1 | `ccr_o` is valid for loading |
| ccr_o | output | 8 | New condition codes |
| ax_load_o | output | 1 | `a_o` and `x_o` are valid for loading |
| a_o | output | 8 | Restored accumulator |
| x_o | output | 8 | Restored index register |

## Verification
The assertions check these rules on every cycle:
- every write stays in the stack page;
- each write is followed by a decrement, and each pull reads one above the current pointer;
- a latched request survives until it is granted, and a grant happens only with the mask clear and to the lowest pending line;
- every loaded CCR and PC has its fixed bits;
- `done_o` lasts one cycle.

Some behaviours only the bench scenarios can show:
- the exact byte order of the five-byte frame and its reversal on return;
- a masked request being held and later served in priority order;
- the command priority between stack reset and entry;
- silent wrap after 33 nested calls.

// File: rtl/irq_stack_pkg.sv
package irq_stack_pkg;

    localparam int          ADDR_W      = 16;
    localparam int          OFS_W       = 6;
    localparam logic [9:0]  STACK_PAGE  = 10'b0000000011;
    localparam int          FRAME_BYTES = 5;
    localparam int          CALL_BYTES  = 2;
    localparam int          SLOT_PCL    = 0;
    localparam int          SLOT_PCH    = 1;
    localparam int          SLOT_X      = 2;
    localparam int          SLOT_A      = 3;
    localparam int          SLOT_CCR    = 4;
    localparam int          MASK_BIT    = 3;
    localparam logic [7:0]  CCR_FIXED   = 8'hE0;
    localparam logic [7:0]  CCR_MASKED  = 8'hE8;

    typedef enum logic [2:0] {
        ST_IDLE, ST_PUSH, ST_PULL, ST_VEC_HI, ST_VEC_LO, ST_FINISH
    } seq_state_e;

    typedef enum logic [2:0] {
        K_RESET, K_IRQ, K_CALL, K_RTI, K_RTS
    } seq_kind_e;

    typedef enum logic [1:0] {
        SP_HOLD, SP_LOAD, SP_DEC, SP_INC
    } sp_op_e;

endpackage

// File: rtl/irq_sp_unit.sv
module irq_sp_unit
    import irq_stack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  sp_op_e            op_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] sp_up_o
);

    logic [OFS_W-1:0] ofs_q;
    logic [OFS_W-1:0] ofs_up;

    assign ofs_up  = ofs_q + OFS_W'(1);
    assign sp_o    = {STACK_PAGE, ofs_q};
    assign sp_up_o = {STACK_PAGE, ofs_up};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q <= '1;
        end else begin
            case (op_i)
                SP_LOAD: ofs_q <= '1;
                SP_DEC:  ofs_q <= ofs_q - OFS_W'(1);
                SP_INC:  ofs_q <= ofs_up;
                default: ofs_q <= ofs_q;
            endcase
        end
    end

    assert_rsp_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SP_LOAD) |=> (sp_o == 16'h00FF));

    assert_dec_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SP_DEC) |=> (sp_o[OFS_W-1:0] == $past(sp_o[OFS_W-1:0]) - OFS_W'(1)));

    assert_inc_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == SP_INC) |=> (sp_o[OFS_W-1:0] == $past(sp_o[OFS_W-1:0]) + OFS_W'(1)));

endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
    parameter int N_REQ = 4,
    localparam int ID_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_REQ-1:0] req_i,
    input  logic             mask_i,
    input  logic             take_i,
    output logic             ready_o,
    output logic [ID_W-1:0]  gnt_o
);

    logic [N_REQ-1:0] pend_q;
    logic [N_REQ-1:0] clr;

    always_comb begin
        gnt_o = '0;
        for (int i = N_REQ - 1; i >= 0; i--) begin
            if (pend_q[i]) gnt_o = ID_W'(i);
        end
    end

    always_comb begin
        clr = '0;
        if (take_i) clr[gnt_o] = 1'b1;
    end

    assign ready_o = (|pend_q) && !mask_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | req_i;
    end

    for (genvar g = 0; g < N_REQ; g++) begin : g_hold
        assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (pend_q[g] && !(take_i && (gnt_o == ID_W'(g)))) |=> pend_q[g]);
    end

    assert_take_unmasked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> (!mask_i && pend_q[gnt_o]));

    assert_take_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> ((pend_q & ((N_REQ'(1) << gnt_o) - N_REQ'(1))) == '0));

endmodule

// File: rtl/irq_seq_fsm.sv
module irq_seq_fsm
    import irq_stack_pkg::*;
#(
    parameter int                N_REQ       = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC   = 16'h3FFE,
    parameter logic [ADDR_W-1:0] IRQ_VEC_TOP = 16'h3FFA,
    localparam int ID_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsp_i,
    input  logic              rti_i,
    input  logic              rts_i,
    input  logic              call_i,
    input  logic              enter_i,
    input  logic              ready_i,
    input  logic [ID_W-1:0]   gnt_i,
    output logic              take_o,
    input  logic [15:0]       cpu_pc_i,
    input  logic [7:0]        cpu_a_i,
    input  logic [7:0]        cpu_x_i,
    input  logic [7:0]        cpu_ccr_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [ADDR_W-1:0] sp_up_i,
    output sp_op_e            sp_op_o,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pc_load_o,
    output logic [15:0]       pc_o,
    output logic              ccr_load_o,
    output logic [7:0]        ccr_o,
    output logic              ax_load_o,
    output logic [7:0]        a_o,
    output logic [7:0]        x_o
);

    seq_state_e        state_q;
    seq_kind_e         kind_q;
    logic [2:0]        idx_q;
    logic [2:0]        last_q;
    logic [ID_W-1:0]   gnt_q;
    logic [7:0]        slot_q [FRAME_BYTES];
    logic [ADDR_W-1:0] vec_addr;
    logic              idle, cmd_rsp, cmd_rti, cmd_rts, cmd_call;

    assign idle     = (state_q == ST_IDLE);
    assign cmd_rsp  = idle && rsp_i;
    assign cmd_rti  = idle && !rsp_i && rti_i;
    assign cmd_rts  = idle && !rsp_i && !rti_i && rts_i;
    assign cmd_call = idle && !rsp_i && !rti_i && !rts_i && call_i;
    assign take_o   = idle && !rsp_i && !rti_i && !rts_i && !call_i && enter_i && ready_i;

    assign vec_addr = (kind_q == K_RESET) ? RESET_VEC
                                          : IRQ_VEC_TOP - (ADDR_W'(gnt_q) << 1);

    // state register and captured data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_VEC_HI;
            kind_q  <= K_RESET;
            idx_q   <= '0;
            last_q  <= '0;
            gnt_q   <= '0;
            for (int i = 0; i < FRAME_BYTES; i++) slot_q[i] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_rti) begin
                        kind_q  <= K_RTI;
                        idx_q   <= 3'(SLOT_CCR);
                        state_q <= ST_PULL;
                    end else if (cmd_rts) begin
                        kind_q  <= K_RTS;
                        idx_q   <= 3'(SLOT_PCH);
                        state_q <= ST_PULL;
                    end else if (cmd_call || take_o) begin
                        kind_q           <= cmd_call ? K_CALL : K_IRQ;
                        idx_q            <= '0;
                        last_q           <= cmd_call ? 3'(CALL_BYTES - 1) : 3'(FRAME_BYTES - 1);
                        gnt_q            <= gnt_i;
                        slot_q[SLOT_PCL] <= cpu_pc_i[7:0];
                        slot_q[SLOT_PCH] <= cpu_pc_i[15:8];
                        slot_q[SLOT_X]   <= cpu_x_i;
                        slot_q[SLOT_A]   <= cpu_a_i;
                        slot_q[SLOT_CCR] <= cpu_ccr_i | CCR_FIXED;
                        state_q          <= ST_PUSH;
                    end
                end
                ST_PUSH: begin
                    if (idx_q == last_q)
                        state_q <= (kind_q == K_IRQ) ? ST_VEC_HI : ST_FINISH;
                    else
                        idx_q <= idx_q + 3'd1;
                end
                ST_PULL: begin
                    slot_q[idx_q] <= mem_rdata_i;
                    if (idx_q == 3'd0) state_q <= ST_FINISH;
                    else               idx_q   <= idx_q - 3'd1;
                end
                ST_VEC_HI: begin
                    slot_q[SLOT_PCH] <= mem_rdata_i;
                    state_q          <= ST_VEC_LO;
                end
                ST_VEC_LO: begin
                    slot_q[SLOT_PCL] <= mem_rdata_i;
                    state_q          <= ST_FINISH;
                end
                ST_FINISH: state_q <= ST_IDLE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sp_op_o     = SP_HOLD;
        mem_we_o    = 1'b0;
        mem_re_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        done_o      = 1'b0;
        pc_load_o   = 1'b0;
        ccr_load_o  = 1'b0;
        ax_load_o   = 1'b0;
        pc_o        = {2'b00, slot_q[SLOT_PCH][5:0], slot_q[SLOT_PCL]};
        ccr_o       = '0;
        a_o         = slot_q[SLOT_A];
        x_o         = slot_q[SLOT_X];
        unique case (state_q)
            ST_IDLE: if (cmd_rsp) sp_op_o = SP_LOAD;
            ST_PUSH: begin
                mem_we_o    = 1'b1;
                mem_addr_o  = sp_i;
                mem_wdata_o = slot_q[idx_q];
                sp_op_o     = SP_DEC;
            end
            ST_PULL: begin
                mem_re_o   = 1'b1;
                mem_addr_o = sp_up_i;
                sp_op_o    = SP_INC;
            end
            ST_VEC_HI: begin
                mem_re_o   = 1'b1;
                mem_addr_o = vec_addr;
            end
            ST_VEC_LO: begin
                mem_re_o   = 1'b1;
                mem_addr_o = vec_addr + ADDR_W'(1);
            end
            ST_FINISH: begin
                done_o = 1'b1;
                unique case (kind_q)
                    K_RESET: begin
                        pc_load_o  = 1'b1;
                        ccr_load_o = 1'b1;
                        ccr_o      = CCR_MASKED;
                    end
                    K_IRQ: begin
                        pc_load_o  = 1'b1;
                        ccr_load_o = 1'b1;
                        ccr_o      = slot_q[SLOT_CCR] | CCR_MASKED;
                    end
                    K_RTI: begin
                        pc_load_o  = 1'b1;
                        ccr_load_o = 1'b1;
                        ax_load_o  = 1'b1;
                        ccr_o      = slot_q[SLOT_CCR] | CCR_FIXED;
                    end
                    K_RTS:   pc_load_o = 1'b1;
                    default: ;
                endcase
            end
            default: ;
        endcase
    end

    assign busy_o = !idle;

    assert_vec_after_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_VEC_HI && kind_q == K_IRQ) |->
            ($past(state_q) == ST_PUSH && $past(idx_q) == 3'(FRAME_BYTES - 1)));

    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
    import irq_stack_pkg::*;
#(
    parameter int                N_REQ       = 4,
    parameter logic [ADDR_W-1:0] RESET_VEC   = 16'h3FFE,
    parameter logic [ADDR_W-1:0] IRQ_VEC_TOP = 16'h3FFA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_REQ-1:0]  irq_req_i,
    input  logic [15:0]       cpu_pc_i,
    input  logic [7:0]        cpu_a_i,
    input  logic [7:0]        cpu_x_i,
    input  logic [7:0]        cpu_ccr_i,
    input  logic              enter_i,
    input  logic              rti_i,
    input  logic              call_i,
    input  logic              rts_i,
    input  logic              rsp_i,
    output logic              mem_we_o,
    output logic              mem_re_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic              irq_pending_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              pc_load_o,
    output logic [15:0]       pc_o,
    output logic              ccr_load_o,
    output logic [7:0]        ccr_o,
    output logic              ax_load_o,
    output logic [7:0]        a_o,
    output logic [7:0]        x_o
);

    localparam int ID_W = (N_REQ > 1) ? $clog2(N_REQ) : 1;

    sp_op_e            sp_op;
    logic [ADDR_W-1:0] sp_up;
    logic              ready, take;
    logic [ID_W-1:0]   gnt;

    irq_sp_unit u_sp (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_i    (sp_op),
        .sp_o    (sp_o),
        .sp_up_o (sp_up)
    );

    irq_pend_latch #(.N_REQ(N_REQ)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (irq_req_i),
        .mask_i  (cpu_ccr_i[MASK_BIT]),
        .take_i  (take),
        .ready_o (ready),
        .gnt_o   (gnt)
    );

    irq_seq_fsm #(
        .N_REQ       (N_REQ),
        .RESET_VEC   (RESET_VEC),
        .IRQ_VEC_TOP (IRQ_VEC_TOP)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .rsp_i       (rsp_i),
        .rti_i       (rti_i),
        .rts_i       (rts_i),
        .call_i      (call_i),
        .enter_i     (enter_i),
        .ready_i     (ready),
        .gnt_i       (gnt),
        .take_o      (take),
        .cpu_pc_i    (cpu_pc_i),
        .cpu_a_i     (cpu_a_i),
        .cpu_x_i     (cpu_x_i),
        .cpu_ccr_i   (cpu_ccr_i),
        .sp_i        (sp_o),
        .sp_up_i     (sp_up),
        .sp_op_o     (sp_op),
        .mem_we_o    (mem_we_o),
        .mem_re_o    (mem_re_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .mem_rdata_i (mem_rdata_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .pc_load_o   (pc_load_o),
        .pc_o        (pc_o),
        .ccr_load_o  (ccr_load_o),
        .ccr_o       (ccr_o),
        .ax_load_o   (ax_load_o),
        .a_o         (a_o),
        .x_o         (x_o)
    );

    assign irq_pending_o = ready;

    assert_stack_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o[ADDR_W-1:OFS_W] == STACK_PAGE));

    assert_push_then_dec_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (mem_addr_o == sp_o) ##1 (sp_o[OFS_W-1:0] == $past(sp_o[OFS_W-1:0]) - OFS_W'(1)));

    assert_pull_above_sp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_re_o && mem_addr_o[ADDR_W-1:OFS_W] == STACK_PAGE) |->
            (mem_addr_o[OFS_W-1:0] == sp_o[OFS_W-1:0] + OFS_W'(1)));

    assert_no_rw_clash_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we_o && mem_re_o));

    assert_ccr_fixed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_load_o |-> (ccr_o[7:5] == 3'b111));

    assert_pc_top_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load_o |-> (pc_o[15:14] == 2'b00));

endmodule

// File: tb/test_irq_stack_seq.sv
`timescale 1ns/1ps
module test_irq_stack_seq;

    localparam int N_REQ = 4;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [N_REQ-1:0] irq_req;
    logic [15:0]      cpu_pc;
    logic [7:0]       cpu_a, cpu_x, cpu_ccr;
    logic             enter, rti, call, rts, rsp;
    logic             mem_we, mem_re;
    logic [15:0]      mem_addr;
    logic [7:0]       mem_wdata, mem_rdata;
    logic [15:0]      sp;
    logic             irq_pending, busy, done;
    logic             pc_load, ccr_load, ax_load;
    logic [15:0]      pc;
    logic [7:0]       ccr, a_out, x_out;

    always #2.5 clk = ~clk;

    irq_stack_seq #(.N_REQ(N_REQ)) i_irq_stack_seq (
        .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req),
        .cpu_pc_i(cpu_pc), .cpu_a_i(cpu_a), .cpu_x_i(cpu_x), .cpu_ccr_i(cpu_ccr),
        .enter_i(enter), .rti_i(rti), .call_i(call), .rts_i(rts), .rsp_i(rsp),
        .mem_we_o(mem_we), .mem_re_o(mem_re), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .sp_o(sp),
        .irq_pending_o(irq_pending), .busy_o(busy), .done_o(done),
        .pc_load_o(pc_load), .pc_o(pc), .ccr_load_o(ccr_load), .ccr_o(ccr),
        .ax_load_o(ax_load), .a_o(a_out), .x_o(x_out)
    );

    // memory model: low page RAM plus a 16-byte vector area
    logic [7:0] ram  [0:255];
    logic [7:0] vrom [0:15];

    always_comb begin
        if (mem_addr[15:8] == 8'h00)        mem_rdata = ram[mem_addr[7:0]];
        else if (mem_addr[15:4] == 12'h3FF) mem_rdata = vrom[mem_addr[3:0]];
        else                                mem_rdata = 8'h00;
    end

    typedef struct {
        bit          is_done;
        logic [15:0] addr;
        logic [7:0]  data;
        bit          pc_ld, ccr_ld, ax_ld;
        logic [15:0] pc;
        logic [7:0]  ccr, a, x;
        string       req;
    } exp_t;

    exp_t       q[$];
    exp_t       mon_e;
    int         checks = 0;
    int         errors = 0;
    logic [5:0] bsp;
    logic [7:0] shadow [0:63];

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // monitor: pops expectations as the design produces writes and results
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (mem_we) begin
                if (q.size() == 0 || q[0].is_done) begin
                    chk(0, "R11", "unexpected stack write", {16'h0, mem_addr}, 32'h0);
                end else begin
                    mon_e = q.pop_front();
                    chk(mem_addr == mon_e.addr, mon_e.req, "write address", {16'h0, mem_addr}, {16'h0, mon_e.addr});
                    chk(mem_wdata == mon_e.data, mon_e.req, "write data", {24'h0, mem_wdata}, {24'h0, mon_e.data});
                end
                if (mem_addr[15:8] == 8'h00) ram[mem_addr[7:0]] = mem_wdata;
            end
            if (done) begin
                if (q.size() == 0 || !q[0].is_done) begin
                    chk(0, "R12", "unexpected done", 32'h1, 32'h0);
                end else begin
                    mon_e = q.pop_front();
                    chk(pc_load == mon_e.pc_ld, mon_e.req, "pc_load", {31'h0, pc_load}, {31'h0, mon_e.pc_ld});
                    if (mon_e.pc_ld) chk(pc == mon_e.pc, mon_e.req, "pc", {16'h0, pc}, {16'h0, mon_e.pc});
                    chk(ccr_load == mon_e.ccr_ld, mon_e.req, "ccr_load", {31'h0, ccr_load}, {31'h0, mon_e.ccr_ld});
                    if (mon_e.ccr_ld) chk(ccr == mon_e.ccr, mon_e.req, "ccr", {24'h0, ccr}, {24'h0, mon_e.ccr});
                    chk(ax_load == mon_e.ax_ld, mon_e.req, "ax_load", {31'h0, ax_load}, {31'h0, mon_e.ax_ld});
                    if (mon_e.ax_ld) begin
                        chk(a_out == mon_e.a, mon_e.req, "a", {24'h0, a_out}, {24'h0, mon_e.a});
                        chk(x_out == mon_e.x, mon_e.req, "x", {24'h0, x_out}, {24'h0, mon_e.x});
                    end
                end
            end
        end
    end

    task automatic exp_write(logic [7:0] d, string r);
        exp_t e;
        e.is_done = 0;
        e.addr = {10'b0000000011, bsp};
        e.data = d;
        shadow[bsp] = d;
        bsp = bsp - 6'd1;
        q.push_back(e);
    endtask

    task automatic exp_done(bit pl, logic [15:0] p, bit cl, logic [7:0] c,
                            bit al, logic [7:0] av, logic [7:0] xv, string r);
        exp_t e;
        e.is_done = 1; e.addr = '0; e.data = '0;
        e.pc_ld = pl; e.pc = p; e.ccr_ld = cl; e.ccr = c;
        e.ax_ld = al; e.a = av; e.x = xv; e.req = r;
        q.push_back(e);
    endtask

    function automatic logic [15:0] vec_pc(logic [15:0] hi_addr);
        return {2'b00, vrom[hi_addr[3:0]][5:0], vrom[4'(hi_addr[3:0] + 4'd1)]};
    endfunction

    task automatic wait_done();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 100);
        if (n >= 100) chk(0, "R12", "done timeout", 32'h0, 32'h1);
        @(negedge clk);
        chk(q.size() == 0, "R12", "leftover expectations", q.size(), 32'h0);
    endtask

    // R4 R6: five-byte frame, then vector of line k
    task automatic do_irq(logic [15:0] p, logic [7:0] av, logic [7:0] xv, logic [7:0] c,
                          int k, bit junk);
        exp_write(p[7:0], "R4");
        exp_write(p[15:8], "R4");
        exp_write(xv, "R4");
        exp_write(av, "R4");
        exp_write(c | 8'hE0, "R4");
        exp_done(1, vec_pc(16'h3FFA - 16'(2 * k)), 1, c | 8'hE8, 0, 8'h0, 8'h0, "R6");
        cpu_pc = p; cpu_a = av; cpu_x = xv; cpu_ccr = c;
        enter = 1'b1;
        @(negedge clk);
        enter = 1'b0;
        if (junk) begin
            call = 1'b1;   // R11: strobe during PUSH must be ignored
            @(negedge clk);
            call = 1'b0;
        end
        wait_done();
    endtask

    task automatic do_call(logic [15:0] p);
        exp_write(p[7:0], "R4");
        exp_write(p[15:8], "R4");
        exp_done(0, 16'h0, 0, 8'h0, 0, 8'h0, 8'h0, "R12");
        cpu_pc = p;
        call = 1'b1;
        @(negedge clk);
        call = 1'b0;
        wait_done();
    endtask

    task automatic do_rti();
        logic [7:0] c, av, xv, ph, pl;
        bsp = bsp + 6'd1; c  = shadow[bsp];
        bsp = bsp + 6'd1; av = shadow[bsp];
        bsp = bsp + 6'd1; xv = shadow[bsp];
        bsp = bsp + 6'd1; ph = shadow[bsp];
        bsp = bsp + 6'd1; pl = shadow[bsp];
        exp_done(1, {2'b00, ph[5:0], pl}, 1, c | 8'hE0, 1, av, xv, "R5");
        rti = 1'b1;
        @(negedge clk);
        rti = 1'b0;
        wait_done();
    endtask

    task automatic do_rts();
        logic [7:0] ph, pl;
        bsp = bsp + 6'd1; ph = shadow[bsp];
        bsp = bsp + 6'd1; pl = shadow[bsp];
        exp_done(1, {2'b00, ph[5:0], pl}, 0, 8'h0, 0, 8'h0, 8'h0, "R5");
        rts = 1'b1;
        @(negedge clk);
        rts = 1'b0;
        wait_done();
    endtask

    task automatic do_rsp();
        rsp = 1'b1;
        @(negedge clk);
        rsp = 1'b0;
        bsp = 6'h3F;
        chk(sp == 16'h00FF, "R2", "sp after stack reset", {16'h0, sp}, 32'h00FF);
    endtask

    task automatic pulse_req(logic [N_REQ-1:0] r);
        irq_req = r;
        @(negedge clk);
        irq_req = '0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R12 watchdog actual=expired expected=finish");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; irq_req = '0; cpu_pc = '0; cpu_a = '0; cpu_x = '0; cpu_ccr = '0;
        enter = 0; rti = 0; call = 0; rts = 0; rsp = 0;
        for (int i = 0; i < 256; i++) ram[i] = 8'h00;
        for (int i = 0; i < 16; i++) vrom[i] = 8'(8'hC1 + i * 8'h13);
        for (int i = 0; i < 64; i++) shadow[i] = 8'h00;
        bsp = 6'h3F;

        // R8: reset vector fetch from $3FFE/$3FFF, CCR $E8
        exp_done(1, vec_pc(16'h3FFE), 1, 8'hE8, 0, 8'h0, 8'h0, "R8");
        repeat (3) @(negedge clk);
        chk(sp == 16'h00FF, "R2", "sp in reset", {16'h0, sp}, 32'h00FF);
        chk(done == 1'b0, "R12", "done in reset", {31'h0, done}, 32'h0);
        rst_n = 1'b1;
        wait_done();
        chk(sp == 16'h00FF, "R1", "sp after reset", {16'h0, sp}, 32'h00FF);
        chk(busy == 1'b0, "R11", "idle after reset", {31'h0, busy}, 32'h0);
        chk(irq_pending == 1'b0, "R7", "no request pending", {31'h0, irq_pending}, 32'h0);

        // R6 R9 R11: unmasked request on line 2, stray call during push
        pulse_req(4'b0100);
        chk(irq_pending == 1'b1, "R7", "pending after request", {31'h0, irq_pending}, 32'h1);
        do_irq(16'hF123, 8'hA5, 8'h5A, 8'h01, 2, 1'b1);
        chk(sp == 16'h00FA, "R3", "sp after frame", {16'h0, sp}, 32'h00FA);

        // R7: masked requests are held, entry ignored
        cpu_ccr = 8'hE8;
        pulse_req(4'b1010);
        chk(irq_pending == 1'b0, "R7", "pending while masked", {31'h0, irq_pending}, 32'h0);
        enter = 1'b1;
        @(negedge clk);
        enter = 1'b0;
        repeat (8) @(negedge clk);
        chk(busy == 1'b0, "R7", "no entry while masked", {31'h0, busy}, 32'h0);
        chk(sp == 16'h00FA, "R7", "sp untouched while masked", {16'h0, sp}, 32'h00FA);
        cpu_ccr = 8'h00;
        @(negedge clk);
        chk(irq_pending == 1'b1, "R7", "pending after unmask", {31'h0, irq_pending}, 32'h1);

        // R10: line 1 before line 3
        do_irq(16'h1234, 8'h11, 8'h22, 8'h04, 1, 1'b0);
        do_irq(16'h4321, 8'h33, 8'h44, 8'h02, 3, 1'b0);
        chk(irq_pending == 1'b0, "R10", "all requests served", {31'h0, irq_pending}, 32'h0);

        // R5: unwind three frames
        do_rti();
        do_rti();
        do_rti();
        chk(sp == 16'h00FF, "R5", "sp after returns", {16'h0, sp}, 32'h00FF);

        // R4 R5: call and return
        do_call(16'hC345);
        do_rts();

        // R11: stack reset outranks entry
        do_call(16'h0777);
        pulse_req(4'b0001);
        rsp = 1'b1; enter = 1'b1;
        @(negedge clk);
        rsp = 1'b0; enter = 1'b0;
        bsp = 6'h3F;
        chk(sp == 16'h00FF, "R11", "stack reset wins", {16'h0, sp}, 32'h00FF);
        chk(busy == 1'b0, "R11", "entry dropped", {31'h0, busy}, 32'h0);
        chk(irq_pending == 1'b1, "R11", "request still latched", {31'h0, irq_pending}, 32'h1);
        do_irq(16'h0ABC, 8'h55, 8'h66, 8'h00, 0, 1'b0);
        do_rsp();

        // R3: 33 nested calls wrap the pointer
        for (int i = 0; i < 33; i++) begin
            do_call(16'(16'h0100 + i));
            chk(sp == {10'b0000000011, bsp}, "R3", "sp during wrap", {16'h0, sp}, {26'h0, bsp});
        end
        do_rts();
        do_rsp();

        summary();
        $finish;
    end

endmodule